// File: doc/BRIEF.md
# Sleep-Retentive Pin Direction Controller

This block sets the direction and drive level of 22 general peripheral pins, both in normal operation and across a low-power sleep cycle. Software programs three registers over a simple word-addressed register bus: a normal-mode direction mask, an output level register and a sleep-mode direction mask. In normal operation each pin's output enable comes from the direction mask and its level comes from the output level register.

When the sleep indication rises, the block captures the sleep-mode mask. From then until software releases the pins, every pin follows that captured mask: it is either driven low or left as an input. On wake a hold flag is set, and the pins stay frozen in their sleep configuration. Software reprograms the normal registers, then writes one to the hold flag to give the pins back. The sleep-entry reset clears only the normal direction mask, so the sleep mask and the output levels survive it. A main-power-loss input models the loss of the sleep mask's contents.

Top module: `pin_sleep_ctl`

## Requirements
- R1: Each data register holds 22 bits in bus bits 21..0. Writes to bus bits 31..22 are ignored, and those bits always read as zero.
- R2: Hard reset, soft reset (`soft_rst`) and sleep reset (`sleep_rst`) each clear the normal direction mask to zero, which makes every pin an input outside sleep and hold.
- R3: Hard reset sets the sleep direction mask to all ones. Soft reset and sleep reset leave it unchanged.
- R4: While the pins are frozen, a captured sleep-mask bit of 0 gives `pin_oe`=1 and `pin_out`=0 for that pin, and a bit of 1 gives `pin_oe`=0.
- R5: The sleep mask is captured on the clock edge at which `sleep_i` is first seen high. Later writes to the sleep mask do not change the frozen pins.
- R6: A `pwr_lost` pulse returns the sleep direction mask to all ones on the next edge. It takes priority over a write in the same cycle.
- R7: The clock edge at which `sleep_i` is first seen low after sleep sets the hold flag. While the flag is set, the pins keep the captured sleep configuration, even if the normal registers are written.
- R8: A write to the status address with bit 0 = 1 clears the hold flag. A write with bit 0 = 0 has no effect on it.
- R9: Only hard reset initializes the output level register, which it clears to zero. Soft reset and sleep reset leave it unchanged.
- R10: When neither sleep nor hold is active, `pin_oe` equals the normal direction mask (1 = output) and `pin_out` equals the output level register.
- R11: Register map, by word address: 0 is the normal direction mask, 1 the output level register, 2 the sleep direction mask, and 3 the status word with the hold flag on bit 0. A write takes effect at the clock edge on which `bus_wr` is sampled high. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous hard/power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| sleep_rst | input | 1 | Synchronous reset issued on sleep entry |
| sleep_i | input | 1 | High while the chip is asleep |
| pwr_lost | input | 1 | Main supply removed; sleep mask contents lost |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_oe | output | 22 | Per-pin output enable |
| pin_out | output | 22 | Per-pin output level |

## Verification
On every cycle the assertions check the following: the reserved read bits stay zero, the resets clear the normal mask, the sleep mask is untouched by soft and sleep resets, the frozen output enables equal the inverted mask captured at sleep entry, and the hold flag is set on wake and persists until a write of one. Other behaviour needs ordered scenarios and is shown only by the bench. This covers writes to the sleep mask during sleep not reaching the pins, a power loss during sleep leaving the frozen pins alone, a write of zero leaving the hold in place, and control passing back to freshly written normal registers once hold is released.

// File: rtl/pin_sleep_ctl.sv
module pin_sleep_ctl #(
  parameter int NPINS = 22,
  parameter int DW    = 32,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             hard_rst_n,
  input  logic             soft_rst,
  input  logic             sleep_rst,
  input  logic             sleep_i,
  input  logic             pwr_lost,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out
);

  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_LVL  = AW'(1);
  localparam logic [AW-1:0] A_SDIR = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [NPINS-1:0] ONES = {NPINS{1'b1}};

  logic [NPINS-1:0] dir_q, lvl_q, sdir_q, cap_q;
  logic             sleep_q, hold_q, frozen;
  logic             wr_dir, wr_lvl, wr_sdir, wr_stat;
  logic [NPINS-1:0] wdat;
  logic             unused_wbits;

  assign wr_dir  = bus_wr && (bus_addr == A_DIR);
  assign wr_lvl  = bus_wr && (bus_addr == A_LVL);
  assign wr_sdir = bus_wr && (bus_addr == A_SDIR);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wdat    = bus_wdata[NPINS-1:0];
  assign unused_wbits = ^bus_wdata[DW-1:NPINS];

  always_ff @(posedge clk or negedge hard_rst_n)
    if (!hard_rst_n)              dir_q <= '0;
    else if (soft_rst || sleep_rst) dir_q <= '0;
    else if (wr_dir)              dir_q <= wdat;

  always_ff @(posedge clk or negedge hard_rst_n)
    if (!hard_rst_n)  lvl_q <= '0;
    else if (wr_lvl)  lvl_q <= wdat;

  always_ff @(posedge clk or negedge hard_rst_n)
    if (!hard_rst_n)   sdir_q <= ONES;
    else if (pwr_lost) sdir_q <= ONES;
    else if (wr_sdir)  sdir_q <= wdat;

  always_ff @(posedge clk or negedge hard_rst_n)
    if (!hard_rst_n) begin
      sleep_q <= 1'b0;
      cap_q   <= ONES;
    end else begin
      sleep_q <= sleep_i;
      if (sleep_i && !sleep_q) cap_q <= sdir_q;
    end

  always_ff @(posedge clk or negedge hard_rst_n)
    if (!hard_rst_n)                   hold_q <= 1'b0;
    else if (sleep_q && !sleep_i)      hold_q <= 1'b1;
    else if (wr_stat && bus_wdata[0])  hold_q <= 1'b0;

  assign frozen  = sleep_q | hold_q;
  assign pin_oe  = frozen ? ~cap_q : dir_q;
  assign pin_out = frozen ? '0 : lvl_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIR:   bus_rdata[NPINS-1:0] = dir_q;
      A_LVL:   bus_rdata[NPINS-1:0] = lvl_q;
      A_SDIR:  bus_rdata[NPINS-1:0] = sdir_q;
      default: bus_rdata[0]         = hold_q;
    endcase
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!hard_rst_n)
    bus_rdata[DW-1:NPINS] == '0); // R1
  AST_DIR_CLEARED: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (soft_rst || sleep_rst) |=> dir_q == '0); // R2
  AST_SDIR_KEPT: assert property (@(posedge clk) disable iff (!hard_rst_n)
    ((soft_rst || sleep_rst) && !pwr_lost && !wr_sdir) |=> $stable(sdir_q)); // R3
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(sleep_q) |-> (pin_oe == ~$past(sdir_q) && pin_out == '0)); // R4
  AST_PWR_LOST: assert property (@(posedge clk) disable iff (!hard_rst_n)
    pwr_lost |=> sdir_q == ONES); // R6
  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (sleep_q && !sleep_i) |=> hold_q); // R7
  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (hold_q && !(wr_stat && bus_wdata[0])) |=> hold_q); // R8
  AST_LVL_KEPT: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !wr_lvl |=> $stable(lvl_q)); // R9

endmodule

// File: tb/test_pin_sleep_ctl.sv
module test_pin_sleep_ctl;
  logic        clk = 1'b0;
  logic        hard_rst_n = 1'b0;
  logic        soft_rst = 1'b0, sleep_rst = 1'b0, sleep_i = 1'b0, pwr_lost = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [21:0] pin_oe, pin_out;

  always #2 clk = ~clk;

  pin_sleep_ctl i_pin_sleep_ctl (.*);

  typedef struct { int sel; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.sel == 0) ? bus_rdata : (it.sel == 1) ? {10'd0, pin_oe} : {10'd0, pin_out};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [31:0] e, input string r);
    item_t it;
    bus_addr = a;
    it.sel = 0; it.exp = e; it.req = r; q.push_back(it);
    tick();
  endtask

  task automatic exp_pins(input logic [21:0] oe, input logic [21:0] o, input string r);
    item_t a, b;
    a.sel = 1; a.exp = {10'd0, oe}; a.req = r; q.push_back(a);
    b.sel = 2; b.exp = {10'd0, o};  b.req = r; q.push_back(b);
    tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    hard_rst_n = 1;
    tick();
    exp_pins(22'h0, 22'h0, "R2 reset");
    exp_rd(2, 32'h003F_FFFF, "R3 reset sleep mask");
    exp_rd(1, 32'h0, "R9 reset level");
    exp_rd(3, 32'h0, "R11 hold clear at reset");

    wr(0, 32'hFFFF_FFFF);
    exp_rd(0, 32'h003F_FFFF, "R1 reserved bits");
    wr(1, 32'hFFEA_AAAA);
    exp_rd(1, 32'h002A_AAAA, "R1 R11 level reg");
    exp_pins(22'h3F_FFFF, 22'h2A_AAAA, "R10 all outputs");
    wr(0, 32'h0000_F0F0);
    exp_pins(22'h00_F0F0, 22'h2A_AAAA, "R10 mixed mask");

    soft_rst = 1; tick(); soft_rst = 0;
    exp_pins(22'h0, 22'h2A_AAAA, "R2 soft reset");
    exp_rd(1, 32'h002A_AAAA, "R9 soft reset");
    exp_rd(2, 32'h003F_FFFF, "R3 soft reset");

    wr(2, 32'h0000_00FF);
    wr(0, 32'h003F_FFFF);
    sleep_i = 1; sleep_rst = 1; tick(); sleep_rst = 0;
    exp_pins(22'h3F_FF00, 22'h0, "R4 R5 sleep config");
    exp_rd(0, 32'h0, "R2 sleep reset");
    exp_rd(2, 32'h0000_00FF, "R3 sleep reset");
    exp_rd(1, 32'h002A_AAAA, "R9 sleep reset");

    wr(2, 32'h0000_0123);
    exp_pins(22'h3F_FF00, 22'h0, "R5 write during sleep");
    pwr_lost = 1; tick(); pwr_lost = 0;
    exp_rd(2, 32'h003F_FFFF, "R6 power loss");
    exp_pins(22'h3F_FF00, 22'h0, "R5 after power loss");

    sleep_i = 0; tick();
    exp_rd(3, 32'h1, "R7 hold set on wake");
    exp_pins(22'h3F_FF00, 22'h0, "R7 frozen after wake");
    wr(0, 32'h0000_0003);
    wr(1, 32'h0000_0003);
    exp_pins(22'h3F_FF00, 22'h0, "R7 frozen despite writes");
    wr(3, 32'hFFFF_FFFE);
    exp_rd(3, 32'h1, "R8 write zero");
    exp_pins(22'h3F_FF00, 22'h0, "R8 still frozen");
    wr(3, 32'h0000_0001);
    exp_rd(3, 32'h0, "R8 write one clears");
    exp_pins(22'h00_0003, 22'h00_0003, "R8 R10 control returned");

    hard_rst_n = 0; tick(); hard_rst_n = 1; tick();
    exp_rd(1, 32'h0, "R9 hard reset");
    exp_rd(2, 32'h003F_FFFF, "R3 hard reset");
    exp_pins(22'h0, 22'h0, "R2 hard reset");

    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule